// File: doc/BRIEF.md
# Multi-Target Broadcast Write Sequencer

This block sends one shared data buffer to a list of two-wire bus target addresses, one target after another. A host first fills an address list and a data buffer through simple write ports, then pulses `go` with the number of listed addresses and the number of data bytes. The sequencer checks the command against its storage and a shared 255-entry budget. It then walks the list and drives a byte-level two-wire master: a start, the 7-bit address with the write bit, every data byte, then a stop.

Each target ends in one of three ways: the transfer succeeds, the target refuses a byte (nack), or an external timeout fires. In every case the sequencer closes that target with a stop and moves on to the next list entry. The outcome is latched into a small status array indexed by list position, and the host can read it at any time. An external timeout timer is restarted once for each target. A one-cycle `done` pulse marks the end of the list.

Top module: `bcast_wr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `reject`, `tmr_restart` and `bm_valid` are low, and every status entry reads 0 (no result).
- R2: A `go` seen while idle is rejected with a one-cycle `reject` pulse in the following cycle, with no bus request and no `busy`, when the address count plus the data count exceeds 255, when the address count exceeds MAX_ADDR, or when the data count exceeds MAX_DATA. A command whose total is exactly 255 is accepted.
- R3: A valid `go` with an address count of 0 raises `done` for one cycle in the following cycle. It makes no bus request and never raises `busy`.
- R4: Each listed target, in list order, gets this sequence: START (`bm_cmd`=0); WRITE (`bm_cmd`=1) with byte {addr,0}; WRITE of data bytes 0 to N-1 in order; STOP (`bm_cmd`=2). Every target receives the same data bytes.
- R5: When `bm_nack` comes with `bm_done` on the address byte or on any data byte, no further byte is written to that target. A STOP follows, the status entry reads 2 (nack), and the next target proceeds normally.
- R6: When `tmo_fire` is high while a START, address or data request is pending, that request is dropped and a STOP is issued. The status entry reads 3 (timeout), and the sequencer continues with the next target. A timeout takes precedence over a `bm_done` in the same cycle.
- R7: `tmr_restart` is high for exactly one cycle per target, in the first cycle of that target's START request.
- R8: A fully acknowledged target gets status 1 (ok). Accepting a new command clears all status entries to 0. `st_rd_code` shows entry `st_rd_idx` combinationally.
- R9: `done` pulses for one cycle in the cycle after the last target's STOP completes. `busy` is high from the cycle after acceptance up to that point and is low while `done` is high.
- R10: While `busy` is high, address loads, data loads and `go` are ignored. The running transfer keeps the bytes stored at acceptance.
- R11: Once raised, `bm_valid` stays high with `bm_cmd` and `bm_wdata` unchanged until `bm_done`. The only exception is a timeout abort, which replaces the request with a STOP.
- R12: With a data count of 0, each target receives START, the address byte and STOP, and is reported ok when its address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_addr_we | input | 1 | Write one address-list entry |
| ld_addr_idx | input | AIW | Address-list position to write |
| ld_addr_val | input | 7 | 7-bit target address |
| ld_data_we | input | 1 | Write one data-buffer byte |
| ld_data_idx | input | DIW | Data-buffer position to write |
| ld_data_val | input | 8 | Data byte |
| go | input | 1 | Start a command (sampled while idle) |
| go_naddr | input | 8 | Number of listed addresses |
| go_ndata | input | 8 | Number of data bytes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-list pulse |
| reject | output | 1 | One-cycle pulse for an invalid command |
| bm_valid | output | 1 | Byte-level bus request pending |
| bm_cmd | output | 2 | Request kind: 0 start, 1 write byte, 2 stop |
| bm_wdata | output | 8 | Byte for a write request |
| bm_done | input | 1 | One-cycle completion of the pending request |
| bm_nack | input | 1 | With `bm_done`: the written byte was not acknowledged |
| tmo_fire | input | 1 | Timeout for the current target |
| tmr_restart | output | 1 | Restart the per-target timeout timer |
| st_rd_idx | input | AIW | Status entry to read |
| st_rd_code | output | 2 | Status: 0 none, 1 ok, 2 nack, 3 timeout |

## Verification
The assertions rely on the bus side pulsing `bm_done` for a single cycle, and only while a request is pending. They also rely on `tmo_fire` not coinciding with `bm_done`. The bench's byte-level model answers only a request it can see, two cycles after it appears, and drops its completion pulse in the next cycle. The bench raises the timeout once, as a one-cycle pulse, only while the model is deliberately withholding an answer to one address byte. That keeps the abort path apart from normal completions.

// File: rtl/bws_pkg.sv
package bws_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_STOP  = 2'd2
    } bus_op_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_OK   = 2'd1,
        RES_NACK = 2'd2,
        RES_TMO  = 2'd3
    } tgt_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_DATA,
        ST_STOP
    } seq_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] n_addr;
        logic [CNT_W-1:0] n_data;
    } job_t;

    // A command is legal when both counts fit storage and their sum fits the budget.
    function automatic logic job_ok(input logic [CNT_W-1:0] na,
                                    input logic [CNT_W-1:0] nd,
                                    input int unsigned max_a,
                                    input int unsigned max_d,
                                    input int unsigned budget);
        logic [CNT_W:0] sum;
        sum = {1'b0, na} + {1'b0, nd};
        return (32'(na) <= max_a) && (32'(nd) <= max_d) && (32'(sum) <= budget);
    endfunction

endpackage

// File: rtl/bws_store.sv
module bws_store #(
    parameter int MAX_ADDR = 32,
    parameter int MAX_DATA = 240,
    localparam int AIW = $clog2(MAX_ADDR),
    localparam int DIW = $clog2(MAX_DATA)
) (
    input  logic           clk,
    input  logic           addr_we,
    input  logic [AIW-1:0] addr_widx,
    input  logic [6:0]     addr_wval,
    input  logic           data_we,
    input  logic [DIW-1:0] data_widx,
    input  logic [7:0]     data_wval,
    input  logic [AIW-1:0] addr_ridx,
    output logic [6:0]     addr_rval,
    input  logic [DIW-1:0] data_ridx,
    output logic [7:0]     data_rval
);
    logic [6:0] addr_mem [MAX_ADDR];
    logic [7:0] data_mem [MAX_DATA];

    always_ff @(posedge clk) begin
        if (addr_we) addr_mem[addr_widx] <= addr_wval;
        if (data_we) data_mem[data_widx] <= data_wval;
    end

    assign addr_rval = addr_mem[addr_ridx];
    assign data_rval = data_mem[data_ridx];
endmodule

// File: rtl/bws_status.sv
module bws_status #(
    parameter int MAX_ADDR = 32,
    localparam int AIW = $clog2(MAX_ADDR)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           we,
    input  logic [AIW-1:0] widx,
    input  logic [1:0]     wcode,
    input  logic [AIW-1:0] ridx,
    output logic [1:0]     rcode
);
    logic [1:0] code_q [MAX_ADDR];

    for (genvar i = 0; i < MAX_ADDR; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || clr)
                code_q[i] <= 2'd0;
            else if (we && widx == AIW'(i))
                code_q[i] <= wcode;
        end
    end

    assign rcode = code_q[ridx];
endmodule

// File: rtl/bws_fsm.sv
module bws_fsm import bws_pkg::*; #(
    parameter int MAX_ADDR = 32,
    parameter int MAX_DATA = 240,
    parameter int BUDGET   = 255,
    localparam int AIW = $clog2(MAX_ADDR),
    localparam int DIW = $clog2(MAX_DATA)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] go_naddr,
    input  logic [CNT_W-1:0] go_ndata,
    input  logic [6:0]       addr_rval,
    input  logic [7:0]       data_rval,
    output logic [AIW-1:0]   addr_ridx,
    output logic [DIW-1:0]   data_ridx,
    input  logic             bm_done,
    input  logic             bm_nack,
    input  logic             tmo_fire,
    output logic             bm_valid,
    output logic [1:0]       bm_cmd,
    output logic [7:0]       bm_wdata,
    output logic             busy,
    output logic             done,
    output logic             reject,
    output logic             tmr_restart,
    output logic             st_clr,
    output logic             st_we,
    output logic [AIW-1:0]   st_widx,
    output logic [1:0]       st_wcode
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] tgt_q, tgt_d;
    logic [CNT_W-1:0] didx_q, didx_d;
    job_t             job_q, job_d;
    tgt_res_e         res_q, res_d;
    logic             done_q, done_d;
    logic             reject_q, reject_d;
    logic             restart_q, restart_d;
    logic             last_tgt, last_byte;

    assign last_tgt  = (tgt_q == job_q.n_addr - 8'd1);
    assign last_byte = (didx_q == job_q.n_data - 8'd1);

    always_comb begin
        state_d  = state_q;
        tgt_d    = tgt_q;
        didx_d   = didx_q;
        job_d    = job_q;
        res_d    = res_q;
        done_d   = 1'b0;
        reject_d = 1'b0;
        st_clr   = 1'b0;
        st_we    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (!job_ok(go_naddr, go_ndata, MAX_ADDR, MAX_DATA, BUDGET)) begin
                        reject_d = 1'b1;
                    end else if (go_naddr == '0) begin
                        done_d = 1'b1;
                    end else begin
                        job_d   = '{n_addr: go_naddr, n_data: go_ndata};
                        tgt_d   = '0;
                        didx_d  = '0;
                        st_clr  = 1'b1;
                        state_d = ST_START;
                    end
                end
            end
            ST_START: begin
                if (tmo_fire) begin
                    res_d   = RES_TMO;
                    state_d = ST_STOP;
                end else if (bm_done) begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (tmo_fire) begin
                    res_d   = RES_TMO;
                    state_d = ST_STOP;
                end else if (bm_done) begin
                    if (bm_nack) begin
                        res_d   = RES_NACK;
                        state_d = ST_STOP;
                    end else if (job_q.n_data == '0) begin
                        res_d   = RES_OK;
                        state_d = ST_STOP;
                    end else begin
                        didx_d  = '0;
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (tmo_fire) begin
                    res_d   = RES_TMO;
                    state_d = ST_STOP;
                end else if (bm_done) begin
                    if (bm_nack) begin
                        res_d   = RES_NACK;
                        state_d = ST_STOP;
                    end else if (last_byte) begin
                        res_d   = RES_OK;
                        state_d = ST_STOP;
                    end else begin
                        didx_d = didx_q + 8'd1;
                    end
                end
            end
            ST_STOP: begin
                if (bm_done) begin
                    st_we = 1'b1;
                    if (last_tgt) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        tgt_d   = tgt_q + 8'd1;
                        state_d = ST_START;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        restart_d = (state_d == ST_START) && (state_q != ST_START);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tgt_q     <= '0;
            didx_q    <= '0;
            job_q     <= '0;
            res_q     <= RES_NONE;
            done_q    <= 1'b0;
            reject_q  <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            tgt_q     <= tgt_d;
            didx_q    <= didx_d;
            job_q     <= job_d;
            res_q     <= res_d;
            done_q    <= done_d;
            reject_q  <= reject_d;
            restart_q <= restart_d;
        end
    end

    assign addr_ridx   = tgt_q[AIW-1:0];
    assign data_ridx   = didx_q[DIW-1:0];
    assign st_widx     = tgt_q[AIW-1:0];
    assign st_wcode    = res_q;
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign reject      = reject_q;
    assign tmr_restart = restart_q;
    assign bm_valid    = (state_q != ST_IDLE);

    always_comb begin
        bm_cmd   = BUS_START;
        bm_wdata = 8'h00;
        unique case (state_q)
            ST_ADDR: begin
                bm_cmd   = BUS_WRITE;
                bm_wdata = {addr_rval, 1'b0};
            end
            ST_DATA: begin
                bm_cmd   = BUS_WRITE;
                bm_wdata = data_rval;
            end
            ST_STOP:  bm_cmd = BUS_STOP;
            default:  bm_cmd = BUS_START;
        endcase
    end
endmodule

// File: rtl/bcast_wr_seq.sv
module bcast_wr_seq import bws_pkg::*; #(
    parameter int MAX_ADDR = 32,
    parameter int MAX_DATA = 240,
    parameter int BUDGET   = 255,
    localparam int AIW = $clog2(MAX_ADDR),
    localparam int DIW = $clog2(MAX_DATA)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_addr_we,
    input  logic [AIW-1:0] ld_addr_idx,
    input  logic [6:0]     ld_addr_val,
    input  logic           ld_data_we,
    input  logic [DIW-1:0] ld_data_idx,
    input  logic [7:0]     ld_data_val,
    input  logic           go,
    input  logic [7:0]     go_naddr,
    input  logic [7:0]     go_ndata,
    output logic           busy,
    output logic           done,
    output logic           reject,
    output logic           bm_valid,
    output logic [1:0]     bm_cmd,
    output logic [7:0]     bm_wdata,
    input  logic           bm_done,
    input  logic           bm_nack,
    input  logic           tmo_fire,
    output logic           tmr_restart,
    input  logic [AIW-1:0] st_rd_idx,
    output logic [1:0]     st_rd_code
);
    logic [AIW-1:0] addr_ridx;
    logic [DIW-1:0] data_ridx;
    logic [6:0]     addr_rval;
    logic [7:0]     data_rval;
    logic           st_clr, st_we;
    logic [AIW-1:0] st_widx;
    logic [1:0]     st_wcode;

    bws_store #(.MAX_ADDR(MAX_ADDR), .MAX_DATA(MAX_DATA)) u_store (
        .clk       (clk),
        .addr_we   (ld_addr_we && !busy),
        .addr_widx (ld_addr_idx),
        .addr_wval (ld_addr_val),
        .data_we   (ld_data_we && !busy),
        .data_widx (ld_data_idx),
        .data_wval (ld_data_val),
        .addr_ridx (addr_ridx),
        .addr_rval (addr_rval),
        .data_ridx (data_ridx),
        .data_rval (data_rval)
    );

    bws_status #(.MAX_ADDR(MAX_ADDR)) u_status (
        .clk   (clk),
        .rst   (rst),
        .clr   (st_clr),
        .we    (st_we),
        .widx  (st_widx),
        .wcode (st_wcode),
        .ridx  (st_rd_idx),
        .rcode (st_rd_code)
    );

    bws_fsm #(.MAX_ADDR(MAX_ADDR), .MAX_DATA(MAX_DATA), .BUDGET(BUDGET)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .go          (go),
        .go_naddr    (go_naddr),
        .go_ndata    (go_ndata),
        .addr_rval   (addr_rval),
        .data_rval   (data_rval),
        .addr_ridx   (addr_ridx),
        .data_ridx   (data_ridx),
        .bm_done     (bm_done),
        .bm_nack     (bm_nack),
        .tmo_fire    (tmo_fire),
        .bm_valid    (bm_valid),
        .bm_cmd      (bm_cmd),
        .bm_wdata    (bm_wdata),
        .busy        (busy),
        .done        (done),
        .reject      (reject),
        .tmr_restart (tmr_restart),
        .st_clr      (st_clr),
        .st_we       (st_we),
        .st_widx     (st_widx),
        .st_wcode    (st_wcode)
    );
endmodule

// File: rtl/bws_checker.sv
module bws_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       reject,
    input logic       bm_valid,
    input logic [1:0] bm_cmd,
    input logic [7:0] bm_wdata,
    input logic       bm_done,
    input logic       tmo_fire,
    input logic       tmr_restart
);
    // R11: a pending request is held steady until answered, unless aborted by timeout
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (bm_valid && !bm_done && !tmo_fire) |=> (bm_valid && $stable(bm_cmd) && $stable(bm_wdata)));

    // R4: no bus request outside a running command
    assert_bus_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
        bm_valid |-> busy);

    // R9: busy is already low when done is shown
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2: a rejected command leaves the bus and busy flag untouched
    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        reject |-> (!busy && !bm_valid));

    // R7: the timer restart lines up with a START request
    assert_restart_start_R7: assert property (@(posedge clk) disable iff (rst)
        tmr_restart |-> (bm_valid && bm_cmd == 2'd0));

    // R7: the restart pulse lasts one cycle
    assert_restart_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        tmr_restart |=> !tmr_restart);

    // R3: done and reject never coincide
    assert_end_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, reject}));
endmodule

bind bcast_wr_seq bws_checker u_bws_checker (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .reject      (reject),
    .bm_valid    (bm_valid),
    .bm_cmd      (bm_cmd),
    .bm_wdata    (bm_wdata),
    .bm_done     (bm_done),
    .tmo_fire    (tmo_fire),
    .tmr_restart (tmr_restart)
);

// File: tb/bcast_wr_seq_bench.sv
module bcast_wr_seq_bench;
    localparam int AIW = 5;
    localparam int DIW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ld_addr_we = 1'b0;
    logic [AIW-1:0] ld_addr_idx = '0;
    logic [6:0]     ld_addr_val = '0;
    logic           ld_data_we = 1'b0;
    logic [DIW-1:0] ld_data_idx = '0;
    logic [7:0]     ld_data_val = '0;
    logic           go = 1'b0;
    logic [7:0]     go_naddr = '0;
    logic [7:0]     go_ndata = '0;
    logic           busy, done, reject, bm_valid, tmr_restart;
    logic [1:0]     bm_cmd;
    logic [7:0]     bm_wdata;
    logic           bm_done = 1'b0;
    logic           bm_nack = 1'b0;
    logic           tmo_fire = 1'b0;
    logic [AIW-1:0] st_rd_idx = '0;
    logic [1:0]     st_rd_code;

    bcast_wr_seq u_bcast_wr_seq (
        .clk(clk), .rst(rst),
        .ld_addr_we(ld_addr_we), .ld_addr_idx(ld_addr_idx), .ld_addr_val(ld_addr_val),
        .ld_data_we(ld_data_we), .ld_data_idx(ld_data_idx), .ld_data_val(ld_data_val),
        .go(go), .go_naddr(go_naddr), .go_ndata(go_ndata),
        .busy(busy), .done(done), .reject(reject),
        .bm_valid(bm_valid), .bm_cmd(bm_cmd), .bm_wdata(bm_wdata),
        .bm_done(bm_done), .bm_nack(bm_nack), .tmo_fire(tmo_fire),
        .tmr_restart(tmr_restart), .st_rd_idx(st_rd_idx), .st_rd_code(st_rd_code)
    );

    // 50 MHz: 20-unit period
    initial forever #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    initial forever @(posedge clk) cyc++;

    // bench mirror of stored content
    logic [6:0] b_addr [32];
    logic [7:0] b_data [240];

    // bus model configuration (written by main only)
    bit       nack_a_en = 0;
    logic [6:0] nack_a = '0;
    bit       nack_d_en = 0;
    logic [6:0] nack_d_tgt = '0;
    int       nack_d_idx = 0;
    bit       stall_en = 0;
    logic [7:0] stall_byte = '0;
    int       tmo_req = 0;

    // bus model outputs (written by model only)
    logic [9:0] log_q [8192];
    int log_n = 0;
    int last_stop_cyc = 0;

    initial begin : bus_model
        int wait_cnt;
        int pos;
        logic [6:0] cur;
        logic nk;
        wait_cnt = 0; pos = 0; cur = '0;
        forever begin
            @(negedge clk);
            if (bm_done) begin
                bm_done = 1'b0;
                bm_nack = 1'b0;
                wait_cnt = 0;
            end else if (bm_valid && !rst) begin
                wait_cnt++;
                if (wait_cnt >= 2 && !(stall_en && bm_cmd == 2'd1 && bm_wdata == stall_byte)) begin
                    nk = 1'b0;
                    if (bm_cmd == 2'd0) pos = 0;
                    if (bm_cmd == 2'd1) begin
                        if (pos == 0) begin
                            cur = bm_wdata[7:1];
                            nk = nack_a_en && (bm_wdata[7:1] == nack_a);
                        end else begin
                            nk = nack_d_en && (cur == nack_d_tgt) && (pos - 1 == nack_d_idx);
                        end
                        pos++;
                    end
                    if (bm_cmd == 2'd2) last_stop_cyc = cyc;
                    log_q[log_n] = {bm_cmd, bm_wdata};
                    log_n++;
                    bm_done = 1'b1;
                    bm_nack = nk;
                end
            end
        end
    end

    // timeout agent: one pulse per request while the stalled byte is pending
    initial begin : tmo_agent
        int served;
        int hold;
        served = 0; hold = 0;
        forever begin
            @(negedge clk);
            if (tmo_fire) begin
                tmo_fire = 1'b0;
                served++;
                hold = 0;
            end else if (tmo_req != served && bm_valid && bm_cmd == 2'd1 && bm_wdata == stall_byte) begin
                hold++;
                if (hold == 5) tmo_fire = 1'b1;
            end
        end
    end

    // output monitor
    int done_cnt = 0, reject_cnt = 0, restart_cnt = 0, busy_cnt = 0;
    int done_cyc = 0, reject_cyc = 0;
    initial forever begin
        @(negedge clk);
        if (done)        begin done_cnt++; done_cyc = cyc; end
        if (reject)      begin reject_cnt++; reject_cyc = cyc; end
        if (tmr_restart) restart_cnt++;
        if (busy)        busy_cnt++;
    end

    // expectations
    logic [9:0] exp_q [8192];
    int exp_n = 0;
    int go_cyc = 0;
    int log_base = 0, d0 = 0, r0 = 0, rs0 = 0, b0 = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_addr(input int idx, input logic [6:0] v);
        @(negedge clk);
        ld_addr_we = 1'b1; ld_addr_idx = AIW'(idx); ld_addr_val = v;
        b_addr[idx] = v;
        @(negedge clk);
        ld_addr_we = 1'b0;
    endtask

    task automatic load_data(input int idx, input logic [7:0] v);
        @(negedge clk);
        ld_data_we = 1'b1; ld_data_idx = DIW'(idx); ld_data_val = v;
        b_data[idx] = v;
        @(negedge clk);
        ld_data_we = 1'b0;
    endtask

    function automatic logic [1:0] stat(input int idx);
        st_rd_idx = AIW'(idx);
        return st_rd_code;
    endfunction

    task automatic read_stat(input int idx, output logic [1:0] code);
        st_rd_idx = AIW'(idx);
        #1;
        code = st_rd_code;
    endtask

    function automatic void exp_push(input logic [1:0] op, input logic [7:0] b);
        exp_q[exp_n] = {op, b};
        exp_n++;
    endfunction

    // mode 0 ok, 1 nack on address, 2 nack on data byte k, 3 timeout on address
    function automatic void exp_target(input int ti, input int nd, input int mode, input int k);
        exp_push(2'd0, 8'h00);
        if (mode != 3) exp_push(2'd1, {b_addr[ti], 1'b0});
        if (mode == 0) for (int i = 0; i < nd; i++) exp_push(2'd1, b_data[i]);
        if (mode == 2) for (int i = 0; i <= k; i++) exp_push(2'd1, b_data[i]);
        exp_push(2'd2, 8'h00);
    endfunction

    task automatic mark();
        log_base = log_n; d0 = done_cnt; r0 = reject_cnt; rs0 = restart_cnt; b0 = busy_cnt;
        exp_n = 0;
    endtask

    task automatic issue_go(input int na, input int nd);
        @(negedge clk);
        go = 1'b1; go_naddr = 8'(na); go_ndata = 8'(nd); go_cyc = cyc;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 60000 && done_cnt == d0 && reject_cnt == r0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_log(input string req);
        int first_bad;
        chk(log_n - log_base == exp_n, req, "bus op count", log_n - log_base, exp_n);
        first_bad = -1;
        for (int i = 0; i < exp_n && i < log_n - log_base; i++)
            if (first_bad < 0 && log_q[log_base + i] != exp_q[i]) first_bad = i;
        if (first_bad >= 0)
            chk(0, req, "bus op content", int'(log_q[log_base + first_bad]), int'(exp_q[first_bad]));
        else
            chk(1, req, "bus op content", 0, 0);
    endtask

    task automatic check_stats(input string req, input int n, input int codes []);
        logic [1:0] c;
        for (int i = 0; i < n; i++) begin
            read_stat(i, c);
            chk(c == 2'(codes[i]), req, $sformatf("status[%0d]", i), c, codes[i]);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [1:0] c;
        chk(!busy && !done && !reject && !tmr_restart && !bm_valid, "R1", "outputs idle",
            {busy, done, reject, tmr_restart, bm_valid}, 0);
        for (int i = 0; i < 32; i += 7) begin
            read_stat(i, c);
            chk(c == 2'd0, "R1", "status after reset", c, 0);
        end
    endtask

    task automatic t_basic();
        load_addr(0, 7'h10); load_addr(1, 7'h22); load_addr(2, 7'h35);
        for (int i = 0; i < 4; i++) load_data(i, 8'hA1 + 8'(i));
        mark();
        for (int t = 0; t < 3; t++) exp_target(t, 4, 0, 0);
        issue_go(3, 4);
        wait_end();
        check_log("R4");
        check_stats("R8", 3, '{1, 1, 1});
        chk(restart_cnt - rs0 == 3, "R7", "restart pulses", restart_cnt - rs0, 3);
        chk(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
        chk(done_cyc == last_stop_cyc + 1, "R9", "done timing", done_cyc, last_stop_cyc + 1);
        chk(busy_cnt - b0 == done_cyc - go_cyc - 1, "R9", "busy cycles", busy_cnt - b0, done_cyc - go_cyc - 1);
    endtask

    task automatic t_nack();
        for (int t = 0; t < 4; t++) load_addr(t, 7'h11 + 7'(t));
        for (int i = 0; i < 5; i++) load_data(i, 8'h30 + 8'(i));
        nack_a_en = 1; nack_a = 7'h12;
        nack_d_en = 1; nack_d_tgt = 7'h13; nack_d_idx = 2;
        mark();
        exp_target(0, 5, 0, 0); exp_target(1, 5, 1, 0);
        exp_target(2, 5, 2, 2); exp_target(3, 5, 0, 0);
        issue_go(4, 5);
        wait_end();
        nack_a_en = 0; nack_d_en = 0;
        check_log("R5");
        check_stats("R5", 4, '{1, 2, 2, 1});
    endtask

    task automatic t_clear();
        logic [1:0] c;
        mark();
        for (int t = 0; t < 4; t++) exp_target(t, 5, 0, 0);
        issue_go(4, 5);
        read_stat(1, c);
        chk(c == 2'd0, "R8", "status cleared on accept", c, 0);
        wait_end();
        check_log("R8");
        check_stats("R8", 4, '{1, 1, 1, 1});
    endtask

    task automatic t_timeout();
        load_addr(0, 7'h21); load_addr(1, 7'h22); load_addr(2, 7'h23);
        for (int i = 0; i < 3; i++) load_data(i, 8'h60 + 8'(i));
        stall_en = 1; stall_byte = {7'h22, 1'b0}; tmo_req++;
        mark();
        exp_target(0, 3, 0, 0); exp_target(1, 3, 3, 0); exp_target(2, 3, 0, 0);
        issue_go(3, 3);
        wait_end();
        stall_en = 0;
        check_log("R6");
        check_stats("R6", 3, '{1, 3, 1});
        chk(restart_cnt - rs0 == 3, "R7", "restart per target with timeout", restart_cnt - rs0, 3);
    endtask

    task automatic t_zero_data();
        load_addr(0, 7'h30); load_addr(1, 7'h31);
        mark();
        exp_target(0, 0, 0, 0); exp_target(1, 0, 0, 0);
        issue_go(2, 0);
        wait_end();
        check_log("R12");
        check_stats("R12", 2, '{1, 1});
    endtask

    task automatic t_empty();
        mark();
        issue_go(0, 5);
        wait_end();
        chk(done_cnt - d0 == 1, "R3", "done pulses", done_cnt - d0, 1);
        chk(done_cyc == go_cyc + 1, "R3", "done cycle", done_cyc, go_cyc + 1);
        chk(log_n == log_base, "R3", "bus ops", log_n - log_base, 0);
        chk(busy_cnt == b0, "R3", "busy cycles", busy_cnt - b0, 0);
    endtask

    task automatic t_reject();
        mark();
        issue_go(20, 240);
        wait_end();
        chk(reject_cnt - r0 == 1, "R2", "reject on budget", reject_cnt - r0, 1);
        chk(reject_cyc == go_cyc + 1, "R2", "reject cycle", reject_cyc, go_cyc + 1);
        mark();
        issue_go(33, 1);
        wait_end();
        chk(reject_cnt - r0 == 1, "R2", "reject on address storage", reject_cnt - r0, 1);
        mark();
        issue_go(1, 241);
        wait_end();
        chk(reject_cnt - r0 == 1, "R2", "reject on data storage", reject_cnt - r0, 1);
        chk(log_n == log_base && busy_cnt == b0 && done_cnt == d0, "R2", "no activity", log_n - log_base, 0);
    endtask

    task automatic t_boundary();
        for (int t = 0; t < 15; t++) load_addr(t, 7'h40 + 7'(t));
        for (int i = 0; i < 240; i++) load_data(i, 8'(i * 7 + 3));
        mark();
        for (int t = 0; t < 15; t++) exp_target(t, 240, 0, 0);
        issue_go(15, 240);
        wait_end();
        chk(reject_cnt == r0, "R2", "sum of 255 accepted", reject_cnt - r0, 0);
        check_log("R2");
        chk(restart_cnt - rs0 == 15, "R7", "restart pulses", restart_cnt - rs0, 15);
    endtask

    task automatic t_busy_ignore();
        load_addr(0, 7'h50); load_addr(1, 7'h51);
        for (int i = 0; i < 3; i++) load_data(i, 8'h5A + 8'(i));
        mark();
        exp_target(0, 3, 0, 0); exp_target(1, 3, 0, 0);
        issue_go(2, 3);
        repeat (4) @(negedge clk);
        // stimulus while busy: mirror deliberately not updated
        ld_data_we = 1'b1; ld_data_idx = '0; ld_data_val = 8'hEE;
        ld_addr_we = 1'b1; ld_addr_idx = 5'd1; ld_addr_val = 7'h7F;
        go = 1'b1; go_naddr = 8'd1; go_ndata = 8'd1;
        @(negedge clk);
        ld_data_we = 1'b0; ld_addr_we = 1'b0; go = 1'b0;
        wait_end();
        check_log("R10");
        chk(done_cnt - d0 == 1, "R10", "single done", done_cnt - d0, 1);
        chk(restart_cnt - rs0 == 2, "R10", "restart count", restart_cnt - rs0, 2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nack();
        t_clear();
        t_timeout();
        t_zero_data();
        t_empty();
        t_reject();
        t_busy_ignore();
        t_boundary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule